// File: doc/BRIEF.md
# Always-On Real-Time Clock with Write-Busy Handoff

This block is a real-time clock. Its counters run from a slow, always-running 32.768 kHz clock, and it is programmed over an APB slave that runs on the fast bus clock. The slow domain keeps a milliseconds counter and a seconds counter. A fractional divider advances the milliseconds counter so that exactly `TICK_HZ` ticks occur in every `SLOW_HZ` slow cycles. When the milliseconds counter passes its top value it returns to zero and the seconds counter advances. Two seconds alarms and one milliseconds alarm compare against these counters. Each alarm sets a bit in a sticky status register. The status register is gated by a mask register to drive a single level-high interrupt.

Every APB write is handed across to the slow domain by a toggle handshake. A fast-side state machine has two states. `WR_IDLE` moves to `WR_PENDING` when a write is accepted. `WR_PENDING` returns to `WR_IDLE` when the synchronised acknowledge toggle matches the request toggle. While in `WR_PENDING` the machine holds the address and data stable and shows a busy flag. A write that arrives while busy is dropped. The slow domain publishes a full copy of its state on every slow cycle, and reads are served from that copy. A read of the milliseconds register also captures the matching seconds value into a shadow register. Software reads milliseconds first and then the shadow register, so the two values always belong to the same instant.

Top module: `rtcaon_top`

## Requirements
- R1: After reset the busy flag, both counters, all alarm values, the mask, the status and `irq` read 0.
- R2: The busy flag (bit 0 at offset 0x004) reads 1 from the cycle after an APB write is accepted. It stays 1 until that write has been applied in the slow domain and then returns to 0. APB reads never set it.
- R3: An APB write accepted while busy is 1 is discarded and changes no register.
- R4: While busy is 1, the held write address and data do not change.
- R5: The milliseconds counter counts 0..`MS_MAX` and then wraps to 0, which adds one to seconds. Exactly `TICK_HZ` millisecond ticks occur in any `SLOW_HZ` consecutive slow cycles.
- R6: A read of milliseconds (0x010) copies the seconds value of the same snapshot into the shadow register (0x00C). The shadow value holds until the next milliseconds read.
- R7: Status bit 0 is set when seconds becomes equal to the nonzero value of alarm 0 (0x014). Status bit 1 is set in the same way for alarm 1 (0x018). An alarm value of 0 disables that alarm.
- R8: Status bit 2 is set when milliseconds becomes equal to the nonzero milliseconds alarm value (0x01C). A value of 0 disables it.
- R9: Mask (0x028) and status (0x02C) share one 5-bit layout: bit 0 seconds alarm 0, bit 1 seconds alarm 1, bit 2 milliseconds alarm, bits 3 and 4 countdown alarms. The countdown bits are stored in the mask but never set in status. Bits above 4 read 0.
- R10: A write of x to status leaves status equal to status AND NOT x.
- R11: `irq` is high exactly while some status bit is set whose mask bit is 1.
- R12: A write to seconds (0x008) loads the seconds counter. The alarm and mask registers read back what was written, limited to their widths. Writes to busy, shadow, milliseconds or unmapped offsets change nothing, and unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Fast APB clock |
| presetn | input | 1 | Fast-domain reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| slow_clk | input | 1 | 32.768 kHz counter clock |
| slow_rstn | input | 1 | Slow-domain reset, active low |
| irq | output | 1 | Level-high interrupt |

## Verification
The bench issues a second write while the first is still pending and confirms it is discarded. A design that let it through would corrupt the held data in the middle of the handshake. It measures time across exactly three divider periods, using the milliseconds-then-shadow read pair. A divider that dropped the fractional carry, or a shadow that tracked the live seconds, would show a difference other than 30. It writes an alarm value of zero while seconds is zero, holds an alarm match across a write-one-to-clear, and sets a status bit whose mask bit is off. These catch an alarm that fires when disabled, an alarm that re-arms on a level match, and an interrupt that ignores the mask.

// File: rtl/rtcaon_pkg.sv
package rtcaon_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int IRQ_N  = 5;

    localparam logic [ADDR_W-1:0] OFS_BUSY   = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_SEC    = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_SHADOW = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_MSEC   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_ALM0   = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_ALM1   = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_MSALM  = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h028;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h02C;

    localparam int BIT_SALM0 = 0;
    localparam int BIT_SALM1 = 1;
    localparam int BIT_MSALM = 2;

    typedef enum logic {
        WR_IDLE,
        WR_PENDING
    } wr_state_e;
endpackage

// File: rtl/rtcaon_sync2.sv
module rtcaon_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rtcaon_wr_handoff.sv
module rtcaon_wr_handoff
    import rtcaon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_accept,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_tgl_async,
    output logic              req_tgl,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_data,
    output logic              busy
);
    wr_state_e state_q, state_d;
    logic      ack_s;
    logic      launch;

    rtcaon_sync2 #(.STAGES(2)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_tgl_async), .q(ack_s)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE:    if (wr_accept)        state_d = WR_PENDING;
            WR_PENDING: if (ack_s == req_tgl) state_d = WR_IDLE;
            default:                          state_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    assign launch = (state_q == WR_IDLE) && wr_accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_tgl   <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
        end else if (launch) begin
            req_tgl   <= ~req_tgl;
            hold_addr <= wr_addr;
            hold_data <= wr_data;
        end
    end

    assign busy = (state_q == WR_PENDING);

    // R2: busy follows an accepted write on the next cycle
    p_busy_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);

    // R4: held address and data stay put while the write is pending
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(hold_addr) && $stable(hold_data)));

    // R3: a write arriving while busy launches no new request
    p_drop_while_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_accept) |=> $stable(req_tgl));
endmodule

// File: rtl/rtcaon_core.sv
module rtcaon_core
    import rtcaon_pkg::*;
#(
    parameter int SEC_W   = 32,
    parameter int MS_W    = 10,
    parameter int MS_MAX  = 999,
    parameter int SLOW_HZ = 32768,
    parameter int TICK_HZ = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tgl_async,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ack_tgl,
    output logic              pub_tgl,
    output logic [SEC_W-1:0]  sec_q,
    output logic [MS_W-1:0]   msec_q,
    output logic [SEC_W-1:0]  alm0_q,
    output logic [SEC_W-1:0]  alm1_q,
    output logic [MS_W-1:0]   msalm_q,
    output logic [IRQ_N-1:0]  mask_q,
    output logic [IRQ_N-1:0]  status_q,
    output logic              irq
);
    localparam int ACC_W = $clog2(SLOW_HZ + TICK_HZ) + 1;
    localparam logic [ACC_W-1:0] ACC_STEP = ACC_W'(TICK_HZ);
    localparam logic [ACC_W-1:0] ACC_MOD  = ACC_W'(SLOW_HZ);
    localparam logic [MS_W-1:0]  MS_TOP   = MS_W'(MS_MAX);

    logic             req_s, apply;
    logic             wr_sec, wr_alm0, wr_alm1, wr_msalm, wr_mask, wr_stat;
    logic [ACC_W-1:0] acc_q, acc_sum;
    logic             tick, ms_wrap;
    logic             m0, m1, mms, m0_q, m1_q, mms_q;
    logic [IRQ_N-1:0] set_v, clr_v;

    rtcaon_sync2 #(.STAGES(2)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(req_tgl_async), .q(req_s)
    );

    assign apply    = req_s ^ ack_tgl;
    assign wr_sec   = apply && (wr_addr == OFS_SEC);
    assign wr_alm0  = apply && (wr_addr == OFS_ALM0);
    assign wr_alm1  = apply && (wr_addr == OFS_ALM1);
    assign wr_msalm = apply && (wr_addr == OFS_MSALM);
    assign wr_mask  = apply && (wr_addr == OFS_MASK);
    assign wr_stat  = apply && (wr_addr == OFS_STAT);

    // fractional divider: add TICK_HZ, tick on reaching SLOW_HZ
    assign acc_sum = acc_q + ACC_STEP;
    assign tick    = (acc_sum >= ACC_MOD);
    assign ms_wrap = tick && (msec_q == MS_TOP);

    // alarm matches, armed only on the cycle equality begins
    assign m0  = (alm0_q  != '0) && (sec_q  == alm0_q);
    assign m1  = (alm1_q  != '0) && (sec_q  == alm1_q);
    assign mms = (msalm_q != '0) && (msec_q == msalm_q);

    always_comb begin
        set_v = '0;
        set_v[BIT_SALM0] = m0  && !m0_q;
        set_v[BIT_SALM1] = m1  && !m1_q;
        set_v[BIT_MSALM] = mms && !mms_q;
        clr_v = wr_stat ? wr_data[IRQ_N-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_tgl  <= 1'b0;
            pub_tgl  <= 1'b0;
            acc_q    <= '0;
            msec_q   <= '0;
            sec_q    <= '0;
            alm0_q   <= '0;
            alm1_q   <= '0;
            msalm_q  <= '0;
            mask_q   <= '0;
            status_q <= '0;
            m0_q     <= 1'b0;
            m1_q     <= 1'b0;
            mms_q    <= 1'b0;
        end else begin
            ack_tgl  <= req_s;
            pub_tgl  <= ~pub_tgl;
            acc_q    <= tick ? (acc_sum - ACC_MOD) : acc_sum;
            if (tick) msec_q <= ms_wrap ? '0 : msec_q + 1'b1;
            if (wr_sec)       sec_q <= wr_data[SEC_W-1:0];
            else if (ms_wrap) sec_q <= sec_q + 1'b1;
            if (wr_alm0)  alm0_q  <= wr_data[SEC_W-1:0];
            if (wr_alm1)  alm1_q  <= wr_data[SEC_W-1:0];
            if (wr_msalm) msalm_q <= wr_data[MS_W-1:0];
            if (wr_mask)  mask_q  <= wr_data[IRQ_N-1:0];
            status_q <= (status_q & ~clr_v) | set_v;
            m0_q     <= m0;
            m1_q     <= m1;
            mms_q    <= mms;
        end
    end

    assign irq = |(status_q & mask_q);

    // R5: milliseconds never exceed the top value
    p_ms_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        msec_q <= MS_TOP);

    // R5: wrap returns milliseconds to zero and carries into seconds
    p_ms_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_wrap && !wr_sec) |=> (msec_q == '0) && (sec_q == SEC_W'($past(sec_q) + 1'b1)));

    // R7: seconds alarm 0 status only rises from an enabled alarm
    p_alarm_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[BIT_SALM0]) |-> ($past(alm0_q) != '0));

    // R9: countdown status bits are never raised
    p_cdn_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[IRQ_N-1:BIT_MSALM+1] == '0);

    // R10: a cleared bit with no new match reads zero next cycle
    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wr_data[BIT_SALM1] && !set_v[BIT_SALM1]) |=> !status_q[BIT_SALM1]);
endmodule

// File: rtl/rtcaon_top.sv
module rtcaon_top
    import rtcaon_pkg::*;
#(
    parameter int SEC_W   = 32,
    parameter int MS_W    = 10,
    parameter int MS_MAX  = 999,
    parameter int SLOW_HZ = 32768,
    parameter int TICK_HZ = 1000
) (
    input  logic        pclk,
    input  logic        presetn,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        pready,
    input  logic        slow_clk,
    input  logic        slow_rstn,
    output logic        irq
);
    logic              wr_accept, rd_msec;
    logic              req_tgl, ack_tgl, pub_tgl, pub_s, pub_q, busy;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_data;
    logic [SEC_W-1:0]  c_sec, c_alm0, c_alm1;
    logic [MS_W-1:0]   c_msec, c_msalm;
    logic [IRQ_N-1:0]  c_mask, c_stat;
    logic [SEC_W-1:0]  snap_sec, snap_alm0, snap_alm1, shadow_q;
    logic [MS_W-1:0]   snap_msec, snap_msalm;
    logic [IRQ_N-1:0]  snap_mask, snap_stat;

    assign pready    = 1'b1;
    assign wr_accept = psel && penable && pwrite;
    assign rd_msec   = psel && penable && !pwrite && (paddr == OFS_MSEC);

    rtcaon_wr_handoff u_handoff (
        .clk(pclk), .rst_n(presetn), .wr_accept(wr_accept),
        .wr_addr(paddr), .wr_data(pwdata), .ack_tgl_async(ack_tgl),
        .req_tgl(req_tgl), .hold_addr(hold_addr), .hold_data(hold_data),
        .busy(busy)
    );

    rtcaon_core #(
        .SEC_W(SEC_W), .MS_W(MS_W), .MS_MAX(MS_MAX),
        .SLOW_HZ(SLOW_HZ), .TICK_HZ(TICK_HZ)
    ) u_core (
        .clk(slow_clk), .rst_n(slow_rstn), .req_tgl_async(req_tgl),
        .wr_addr(hold_addr), .wr_data(hold_data), .ack_tgl(ack_tgl),
        .pub_tgl(pub_tgl), .sec_q(c_sec), .msec_q(c_msec),
        .alm0_q(c_alm0), .alm1_q(c_alm1), .msalm_q(c_msalm),
        .mask_q(c_mask), .status_q(c_stat), .irq(irq)
    );

    rtcaon_sync2 #(.STAGES(2)) u_pub_sync (
        .clk(pclk), .rst_n(presetn), .d(pub_tgl), .q(pub_s)
    );

    // slow-domain state is stable for a whole slow cycle after each publish toggle
    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            pub_q      <= 1'b0;
            snap_sec   <= '0;
            snap_msec  <= '0;
            snap_alm0  <= '0;
            snap_alm1  <= '0;
            snap_msalm <= '0;
            snap_mask  <= '0;
            snap_stat  <= '0;
            shadow_q   <= '0;
        end else begin
            pub_q <= pub_s;
            if (pub_s != pub_q) begin
                snap_sec   <= c_sec;
                snap_msec  <= c_msec;
                snap_alm0  <= c_alm0;
                snap_alm1  <= c_alm1;
                snap_msalm <= c_msalm;
                snap_mask  <= c_mask;
                snap_stat  <= c_stat;
            end
            if (rd_msec) shadow_q <= snap_sec;
        end
    end

    always_comb begin
        case (paddr)
            OFS_BUSY:   prdata = 32'(busy);
            OFS_SEC:    prdata = 32'(snap_sec);
            OFS_SHADOW: prdata = 32'(shadow_q);
            OFS_MSEC:   prdata = 32'(snap_msec);
            OFS_ALM0:   prdata = 32'(snap_alm0);
            OFS_ALM1:   prdata = 32'(snap_alm1);
            OFS_MSALM:  prdata = 32'(snap_msalm);
            OFS_MASK:   prdata = 32'(snap_mask);
            OFS_STAT:   prdata = 32'(snap_stat);
            default:    prdata = '0;
        endcase
    end

    // R6: a milliseconds read captures the seconds of the same snapshot
    p_shadow_latch_r6: assert property (@(posedge pclk) disable iff (!presetn)
        rd_msec |=> (shadow_q == $past(snap_sec)));

    // R6: the shadow holds between milliseconds reads
    p_shadow_hold_r6: assert property (@(posedge pclk) disable iff (!presetn)
        !$past(rd_msec) |-> $stable(shadow_q));
endmodule

// File: tb/rtcaon_top_tb_top.sv
module rtcaon_top_tb_top;
    import rtcaon_pkg::*;

    localparam int TB_SLOW_HZ = 36;
    localparam int TB_TICK_HZ = 10;
    localparam int TB_MS_MAX  = 9;
    localparam longint SLOW_PERIOD = 96;

    typedef struct packed {
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] rexp;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{addr: OFS_ALM0,  wdata: 32'h1234_5678, rexp: 32'h1234_5678},
        '{addr: OFS_ALM1,  wdata: 32'h0000_00A5, rexp: 32'h0000_00A5},
        '{addr: OFS_MSALM, wdata: 32'h0000_03FF, rexp: 32'h0000_03FF},
        '{addr: OFS_MASK,  wdata: 32'hFFFF_FFFF, rexp: 32'h0000_001F},
        '{addr: OFS_BUSY,  wdata: 32'h0000_0001, rexp: 32'h0000_0000},
        '{addr: 12'h020,   wdata: 32'h0000_DEAD, rexp: 32'h0000_0000}
    };

    logic        pclk = 1'b0, slow_clk = 1'b0;
    logic        presetn = 1'b0, slow_rstn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, irq;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;
    logic [31:0] rv, m0, s0a, s0b, m1, s1;
    longint      t0;
    int          n;

    always #4 pclk = ~pclk;
    always #48 slow_clk = ~slow_clk;

    rtcaon_top #(
        .SLOW_HZ(TB_SLOW_HZ), .TICK_HZ(TB_TICK_HZ), .MS_MAX(TB_MS_MAX)
    ) dut_i (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .slow_clk(slow_clk), .slow_rstn(slow_rstn), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] b;
        int k;
        k = 0;
        do begin
            apb_rd(OFS_BUSY, b);
            k++;
        end while (b[0] && k < 400);
        check(tag, b, 32'h0);
    endtask

    task automatic wr_done(input logic [11:0] a, input logic [31:0] d, input string tag);
        apb_wr(a, d);
        wait_idle(tag);
    endtask

    task automatic poll_stat(input int bit_i, input int limit, output logic [31:0] st);
        int k;
        k = 0;
        do begin
            apb_rd(OFS_STAT, st);
            k++;
        end while (!st[bit_i] && k < limit);
    endtask

    initial begin
        repeat (150000) @(posedge pclk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge pclk);
        presetn = 1'b1;
        slow_rstn = 1'b1;

        // R1: reset state
        apb_rd(OFS_BUSY, rv);  check("R1 busy after reset", rv, 0);
        apb_rd(OFS_STAT, rv);  check("R1 status after reset", rv, 0);
        apb_rd(OFS_MASK, rv);  check("R1 mask after reset", rv, 0);
        apb_rd(OFS_ALM0, rv);  check("R1 alarm0 after reset", rv, 0);
        apb_rd(OFS_SEC, rv);   check("R1 seconds after reset", rv, 0);
        check("R1 irq after reset", 32'(irq), 0);

        // R2: reads do not set busy
        apb_rd(OFS_SEC, rv);
        apb_rd(OFS_BUSY, rv);  check("R2 busy after read", rv, 0);

        // R2 / R3: busy set by a write, second write dropped
        apb_wr(OFS_ALM1, 32'd7);
        apb_rd(OFS_BUSY, rv);  check("R2 busy after write", rv, 1);
        apb_wr(OFS_ALM1, 32'd9);
        wait_idle("R2 busy returns to zero");
        apb_rd(OFS_ALM1, rv);  check("R3 write while busy discarded", rv, 7);

        // R12 / R9: register readback table
        foreach (VEC[i]) begin
            wr_done(VEC[i].addr, VEC[i].wdata, "R2 idle after table write");
            apb_rd(VEC[i].addr, rv);
            check($sformatf("R12 R9 readback entry %0d", i), rv, VEC[i].rexp);
        end
        wr_done(OFS_ALM0, 0, "R2 idle");
        wr_done(OFS_ALM1, 0, "R2 idle");
        wr_done(OFS_MSALM, 0, "R2 idle");
        wr_done(OFS_MASK, 0, "R2 idle");
        wr_done(OFS_STAT, 32'hFFFF_FFFF, "R2 idle");

        // R5 / R6: shadow coherence and exact fractional rate
        t0 = longint'($time);
        apb_rd(OFS_MSEC, m0);
        check("R5 milliseconds within range", 32'(m0 <= TB_MS_MAX), 1);
        apb_rd(OFS_SHADOW, s0a);
        repeat (500) @(negedge pclk);
        apb_rd(OFS_SHADOW, s0b);
        check("R6 shadow holds between milliseconds reads", s0b, s0a);
        n = int'((t0 + 3 * TB_SLOW_HZ * SLOW_PERIOD - longint'($time)) / 8);
        repeat (n) @(negedge pclk);
        apb_rd(OFS_MSEC, m1);
        apb_rd(OFS_SHADOW, s1);
        check("R5 R6 elapsed ticks over three divider periods",
              32'((s1 * 10 + m1) - (s0a * 10 + m0)), 30);

        // R7: zero alarm value never fires
        wr_done(OFS_MASK, 32'h1, "R2 idle");
        wr_done(OFS_SEC, 0, "R2 idle");
        repeat (60) @(negedge pclk);
        apb_rd(OFS_STAT, rv);  check("R7 alarm value zero is disabled", rv, 0);
        check("R11 irq low with no status", 32'(irq), 0);

        // R7 / R9 / R10 / R11: seconds alarms with mask gating
        wr_done(OFS_ALM1, 32'd101, "R2 idle");
        wr_done(OFS_ALM0, 32'd102, "R2 idle");
        wr_done(OFS_SEC, 32'd100, "R2 idle");
        apb_rd(OFS_SEC, rv);
        check("R12 seconds loaded by write", 32'(rv >= 100 && rv <= 101), 1);
        poll_stat(BIT_SALM0, 600, rv);
        check("R7 R9 both seconds alarms set, countdown bits clear", rv, 32'h3);
        check("R11 irq high for masked-in alarm", 32'(irq), 1);
        wr_done(OFS_STAT, 32'h1, "R2 idle");
        apb_rd(OFS_STAT, rv);  check("R10 write-one clears only bit 0", rv, 32'h2);
        check("R11 irq low when only unmasked bit remains", 32'(irq), 0);
        wr_done(OFS_STAT, 32'hFFFF_FFFF, "R2 idle");
        apb_rd(OFS_STAT, rv);  check("R10 clear all", rv, 0);

        // R8: milliseconds alarm
        wr_done(OFS_MASK, 32'h4, "R2 idle");
        wr_done(OFS_MSALM, 32'd5, "R2 idle");
        poll_stat(BIT_MSALM, 300, rv);
        check("R8 milliseconds alarm sets bit 2", rv & 32'h4, 32'h4);
        check("R11 irq high for milliseconds alarm", 32'(irq), 1);
        wr_done(OFS_MSALM, 0, "R2 idle");
        wr_done(OFS_STAT, 32'h4, "R2 idle");
        apb_rd(OFS_STAT, rv);  check("R10 milliseconds alarm cleared", rv, 0);
        check("R11 irq low after clear", 32'(irq), 0);
        repeat (600) @(negedge pclk);
        apb_rd(OFS_STAT, rv);  check("R8 zero milliseconds alarm stays quiet", rv, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule